// File: doc/BRIEF.md
# Clock Buffer Control Register Slave

This block is the two-wire management slave of a multi-output clock buffer. It watches the sampled clock and data lines of an SMBus segment, answers at a 7-bit address chosen by two three-level strap inputs, and holds the registers that enable or disable each of twenty clock outputs. The straps arrive already decoded to low, middle and high codes. The block captures them each time the power-good input rises, and it stays off the bus while power-good is low.

A host reaches the registers in one of two ways. In single-byte mode it moves one byte to or from a register index. In block mode it moves a run of bytes that begins with a count byte, and the register index advances after every data byte. Bit 7 of the command byte picks the mode and bits 6:0 give the start index. The block also reports the live levels of eight active-low output-enable pins, two fixed identification bytes, and a programmable read-back length.

Both bus lines pass through a two-flop synchronizer and a three-sample majority filter, so a pulse that covers only one sample is dropped.

Top module: `clkbuf_ctl_slave`

## Requirements
- R1: After reset, all twenty enable bits on `out_en` are 1, and register 7 reads 0x08.
- R2: On each rising edge of `pwr_good`, the slave captures its address from the straps (codes L=0, M=1, H=2; code 3 counts as H). The 8-bit write-form addresses for {hi,lo} are LL=D8, LM=DA, LH=DE, ML=C2, MM=C4, MH=C6, HL=CA, HM=CC, HH=CE. The slave acknowledges only its own address.
- R3: A command byte with bit 7 = 1 starts a single-byte transfer at index bits 6:0. A write stores one byte and does not acknowledge a second data byte, which is not stored. A read after a repeated start returns the byte at that index.
- R4: A command byte with bit 7 = 0 starts a block write. A count byte follows, then data bytes that go to consecutive indices starting at the command index. Every byte up to the count is acknowledged.
- R5: A block-write count of 0 or greater than 32 is not acknowledged. The transfer is dropped and no register changes.
- R6: A block read returns register 7 bits 5:0 as a count byte first, then data from consecutive indices, until the host stops acknowledging.
- R7: Register 0 bits 6:3 drive outputs 19:16, register 1 drives outputs 7:0 and register 2 drives outputs 15:8. Register 0 bits 7 and 2:0 read as 0.
- R8: Register 3 returns the live `oe_pin_n` levels, with bit 0 taken from `oe_pin_n[0]`. Register 4 reads 0, register 5 reads 0x23 and register 6 reads 0x5C. Writes to these registers have no effect.
- R9: Only bits 5:0 of register 7 are writable, and bits 7:6 read as 0.
- R10: A low pulse of one sample on either bus line while the clock line is high is ignored. It adds no bit and makes no start or stop.
- R11: While `pwr_good` is low, the slave acknowledges nothing, stores nothing and releases the data line.
- R12: The slave changes its data-line drive only while the filtered clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Power good; its rise captures the straps; when low, the slave is inactive |
| strap_hi | input | 2 | Decoded upper strap code (0=L, 1=M, 2=H) |
| strap_lo | input | 2 | Decoded lower strap code (0=L, 1=M, 2=H) |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| oe_pin_n | input | 8 | Live levels of the eight active-low enable pins |
| sda_oe | output | 1 | 1 pulls the data line low |
| out_en | output | 20 | Active-high output enables, bit n for output n |

## Verification
The hardest cases to reach from the ports are glitch rejection and the behaviour at the count boundaries. For glitches, the bench drops a single-clock low pulse onto the clock line, or onto the data line during a 1 bit, while the clock is high. It then reads the register back to show that no bit was added and no start or stop was seen. For the count limits, block writes carry counts of 0, 33 and 32, with data bytes sent after the count anyway. The bench checks the acknowledge pattern of every byte and confirms at `out_en` that nothing changed. Random single-byte writes and reads across all eight indices are compared against a bench model of the register map.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int NUM_OUT   = 20;
    localparam int NUM_PIN   = 8;
    localparam int IDX_W     = 7;
    localparam int MAX_COUNT = 32;
    localparam int CNT_W     = $clog2(MAX_COUNT + 1);

    localparam logic [7:0] ID_VENDOR_REV = 8'h23;
    localparam logic [7:0] ID_DEVICE     = 8'h5C;
    localparam logic [5:0] RDLEN_DEFAULT = 6'd8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
    } bus_st_e;

    typedef enum logic [1:0] {
        RK_ADDR, RK_CMD, RK_CNT, RK_DATA
    } rx_kind_e;

    function automatic logic [6:0] strap_addr(input logic [1:0] hi, input logic [1:0] lo);
        logic [1:0] h;
        logic [1:0] l;
        logic [7:0] a;
        h = (hi == 2'd3) ? 2'd2 : hi;
        l = (lo == 2'd3) ? 2'd2 : lo;
        case ({h, l})
            4'b0000: a = 8'hD8;
            4'b0001: a = 8'hDA;
            4'b0010: a = 8'hDE;
            4'b0100: a = 8'hC2;
            4'b0101: a = 8'hC4;
            4'b0110: a = 8'hC6;
            4'b1000: a = 8'hCA;
            4'b1001: a = 8'hCC;
            default: a = 8'hCE;
        endcase
        return a[7:1];
    endfunction
endpackage

// File: rtl/cbs_line_filter.sv
module cbs_line_filter #(
    parameter int SMP_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lvl
);
    localparam int DW = (SMP_DIV > 1) ? $clog2(SMP_DIV) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [2:0]    hist;
        logic          lvl;
        logic [DW-1:0] div;
    } flt_t;

    flt_t q, d;
    logic tick;

    generate
        if (SMP_DIV > 1) begin : g_div
            assign tick = (q.div == DW'(SMP_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_comb begin
        d = q;
        d.sync = {q.sync[0], raw};
        if (SMP_DIV > 1) begin
            d.div = tick ? '0 : q.div + 1'b1;
        end
        if (tick) begin
            d.hist = {q.hist[1:0], q.sync[1]};
        end
        d.lvl = (q.hist[0] & q.hist[1]) | (q.hist[0] & q.hist[2]) | (q.hist[1] & q.hist[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, hist: 3'b111, lvl: 1'b1, div: '0};
        end else begin
            q <= d;
        end
    end

    assign lvl = q.lvl;
endmodule

// File: rtl/cbs_regfile.sv
module cbs_regfile
    import cbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_PIN-1:0] pin_lvl,
    output logic [7:0]         rd_data,
    output logic [5:0]         rd_len,
    output logic [NUM_OUT-1:0] out_en
);
    typedef struct packed {
        logic [3:0] en_hi;
        logic [7:0] en_a;
        logic [7:0] en_b;
        logic [5:0] len;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_idx)
                7'd0: d.en_hi = wr_data[6:3];
                7'd1: d.en_a  = wr_data;
                7'd2: d.en_b  = wr_data;
                7'd7: d.len   = wr_data[5:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en_hi: '1, en_a: '1, en_b: '1, len: RDLEN_DEFAULT};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (rd_idx)
            7'd0:    rd_data = {1'b0, q.en_hi, 3'b000};
            7'd1:    rd_data = q.en_a;
            7'd2:    rd_data = q.en_b;
            7'd3:    rd_data = pin_lvl;
            7'd5:    rd_data = ID_VENDOR_REV;
            7'd6:    rd_data = ID_DEVICE;
            7'd7:    rd_data = {2'b00, q.len};
            default: rd_data = 8'h00;
        endcase
    end

    assign rd_len = q.len;
    assign out_en = {q.en_hi, q.en_b, q.en_a};
endmodule

// File: rtl/cbs_proto.sv
module cbs_proto
    import cbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic [1:0]       strap_hi,
    input  logic [1:0]       strap_lo,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [7:0]       rd_data,
    input  logic [5:0]       rd_len,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             scl_fall,
    output logic [CNT_W-1:0] cnt_left
);
    typedef struct packed {
        bus_st_e          st;
        rx_kind_e         kind;
        logic [3:0]       bitcnt;
        logic [7:0]       sh;
        logic [IDX_W-1:0] idx;
        logic             blk;
        logic [CNT_W-1:0] left;
        logic             to_tx;
        logic             acked;
        logic             oe;
        logic             scl_p;
        logic             sda_p;
        logic             pg_p;
        logic [6:0]       addr;
    } prot_t;

    prot_t q, d;
    logic rise, fall, start_ev, stop_ev;

    assign rise     = scl_f & ~q.scl_p;
    assign fall     = ~scl_f & q.scl_p;
    assign start_ev = scl_f & q.scl_p & q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & q.scl_p & ~q.sda_p & sda_f;

    always_comb begin
        d = q;
        wr_en = 1'b0;
        d.scl_p = scl_f;
        d.sda_p = sda_f;
        d.pg_p  = pwr_good;
        if (pwr_good && !q.pg_p) begin
            d.addr = strap_addr(strap_hi, strap_lo);
        end

        if (!pwr_good) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_ev) begin
            d.st = ST_RX;
            d.kind = RK_ADDR;
            d.bitcnt = '0;
            d.oe = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (rise) begin
                        d.sh = {q.sh[6:0], sda_f};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        d.st = ST_WAIT;
                        case (q.kind)
                            RK_ADDR: begin
                                if (q.sh[7:1] == q.addr) begin
                                    d.st = ST_ACK;
                                    d.oe = 1'b1;
                                    d.to_tx = q.sh[0];
                                    d.kind = RK_CMD;
                                end
                            end
                            RK_CMD: begin
                                d.st = ST_ACK;
                                d.oe = 1'b1;
                                d.to_tx = 1'b0;
                                d.blk = ~q.sh[7];
                                d.idx = q.sh[6:0];
                                d.kind = q.sh[7] ? RK_DATA : RK_CNT;
                                d.left = q.sh[7] ? CNT_W'(1) : '0;
                            end
                            RK_CNT: begin
                                if (q.sh != 8'd0 && q.sh <= 8'(MAX_COUNT)) begin
                                    d.st = ST_ACK;
                                    d.oe = 1'b1;
                                    d.to_tx = 1'b0;
                                    d.left = q.sh[CNT_W-1:0];
                                    d.kind = RK_DATA;
                                end
                            end
                            default: begin
                                if (q.left != '0) begin
                                    wr_en = 1'b1;
                                    d.left = q.left - 1'b1;
                                    if (q.blk) d.idx = q.idx + 1'b1;
                                    d.st = ST_ACK;
                                    d.oe = 1'b1;
                                    d.to_tx = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        d.bitcnt = '0;
                        if (q.to_tx) begin
                            d.st = ST_TX;
                            d.sh = q.blk ? {2'b00, rd_len} : rd_data;
                            d.oe = q.blk ? 1'b1 : ~rd_data[7];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_TXACK;
                            d.bitcnt = '0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (rise) begin
                        d.acked = ~sda_f;
                    end else if (fall) begin
                        if (q.acked) begin
                            d.st = ST_TX;
                            d.sh = rd_data;
                            d.oe = ~rd_data[7];
                            if (q.blk) d.idx = q.idx + 1'b1;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: RK_ADDR, bitcnt: '0, sh: '0, idx: '0, blk: 1'b0,
                   left: '0, to_tx: 1'b0, acked: 1'b0, oe: 1'b0, scl_p: 1'b1,
                   sda_p: 1'b1, pg_p: 1'b0, addr: strap_addr(2'd0, 2'd0)};
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.oe;
    assign wr_idx   = q.idx;
    assign wr_data  = q.sh;
    assign rd_idx   = q.idx;
    assign scl_fall = fall;
    assign cnt_left = q.left;
endmodule

// File: rtl/clkbuf_ctl_slave.sv
module clkbuf_ctl_slave
    import cbs_pkg::*;
#(
    parameter int SMP_DIV = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic [1:0]         strap_hi,
    input  logic [1:0]         strap_lo,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [NUM_PIN-1:0] oe_pin_n,
    output logic               sda_oe,
    output logic [NUM_OUT-1:0] out_en
);
    logic             scl_f, sda_f, scl_fall, wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;
    logic [5:0]       rd_len;
    logic [CNT_W-1:0] cnt_left;

    cbs_line_filter #(.SMP_DIV(SMP_DIV)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw(scl_in), .lvl(scl_f)
    );

    cbs_line_filter #(.SMP_DIV(SMP_DIV)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw(sda_in), .lvl(sda_f)
    );

    cbs_proto u_proto (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .strap_hi(strap_hi), .strap_lo(strap_lo),
        .scl_f(scl_f), .sda_f(sda_f), .rd_data(rd_data), .rd_len(rd_len),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .scl_fall(scl_fall), .cnt_left(cnt_left)
    );

    cbs_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .pin_lvl(oe_pin_n),
        .rd_data(rd_data), .rd_len(rd_len), .out_en(out_en)
    );
endmodule

// File: rtl/cbs_checks.sv
module cbs_checks
    import cbs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_good,
    input logic               scl_f,
    input logic               scl_fall,
    input logic               sda_oe,
    input logic [NUM_OUT-1:0] out_en,
    input logic [CNT_W-1:0]   left
);
    // R11: data line released one cycle after power-good drops
    a_r11_release_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sda_oe);

    // R12: drive stays put while the filtered clock line is high
    a_r12_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && pwr_good && $past(pwr_good)) |-> $stable(sda_oe));

    // R5: remaining byte budget never exceeds the largest legal count
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left <= CNT_W'(MAX_COUNT));

    // R4: enables only move as a byte is acknowledged, on a clock-line fall
    a_r4_en_update_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en != $past(out_en)) |-> $past(scl_fall));
endmodule

bind clkbuf_ctl_slave cbs_checks u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .scl_f(scl_f),
    .scl_fall(scl_fall), .sda_oe(sda_oe), .out_en(out_en), .left(cnt_left)
);

// File: tb/sim_clkbuf_ctl_slave.sv
module sim_clkbuf_ctl_slave;
    localparam int CLK_NS = 10;
    localparam int Q      = 10;
    localparam int WDOG   = 180000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic [1:0] strap_hi = 2'd0, strap_lo = 2'd0;
    logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
    logic [7:0] oe_pin_n = 8'h00;
    logic sda_oe;
    logic [19:0] out_en;
    logic scl_in, sda_in;

    assign scl_in = m_scl & ~g_scl;
    assign sda_in = m_sda & ~sda_oe & ~g_sda;

    always #(CLK_NS/2) clk = ~clk;

    clkbuf_ctl_slave u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .strap_hi(strap_hi), .strap_lo(strap_lo),
        .scl_in(scl_in), .sda_in(sda_in), .oe_pin_n(oe_pin_n),
        .sda_oe(sda_oe), .out_en(out_en)
    );

    int n_chk = 0, n_err = 0, r12_bad = 0;
    int bit_no = 0, glitch_at = -1, glitch_sda = 0;
    logic [19:0] m_en = '1;
    logic [5:0]  m_bc = 6'd8;
    logic [7:0]  wbuf [0:39];
    logic [7:0]  rbuf [0:15];
    logic [6:0]  dev;
    bit done = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_addr(input int hi, input int lo);
        logic [7:0] t [0:8];
        t = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};
        return t[hi*3 + lo][7:1];
    endfunction

    function automatic logic [7:0] exp_reg(input int i);
        case (i)
            0: return {1'b0, m_en[19:16], 3'b000};
            1: return m_en[7:0];
            2: return m_en[15:8];
            3: return oe_pin_n;
            5: return 8'h23;
            6: return 8'h5C;
            7: return {2'b00, m_bc};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_wr(input int i, input logic [7:0] v);
        case (i)
            0: m_en[19:16] = v[6:3];
            1: m_en[7:0] = v;
            2: m_en[15:8] = v;
            7: m_bc = v[5:0];
            default: ;
        endcase
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        logic v1;
        m_sda = b;
        qwait();
        m_scl = 1'b1;
        qwait();
        r = sda_in;
        v1 = sda_in;
        if (bit_no == glitch_at) begin
            if (glitch_sda != 0) g_sda = 1'b1; else g_scl = 1'b1;
            @(negedge clk);
            g_sda = 1'b0;
            g_scl = 1'b0;
        end
        qwait();
        if (sda_in !== v1 && b) r12_bad++;
        m_scl = 1'b0;
        bit_no++;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait(); qwait();
    endtask

    task automatic byte_w(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(v[i], r);
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic byte_r(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            v[i] = r;
        end
        bit_io(~give_ack, r);
    endtask

    task automatic wr_xfer(input logic [6:0] a, input int nb, output logic [63:0] mask);
        logic k;
        mask = '0;
        bus_start();
        byte_w({a, 1'b0}, k); mask[0] = k;
        for (int i = 0; i < nb; i++) begin
            byte_w(wbuf[i], k); mask[i+1] = k;
        end
        bus_stop();
    endtask

    task automatic rd_xfer(input logic [6:0] a, input logic [7:0] cmd, input int n, output logic [2:0] mask);
        logic k;
        bus_start();
        byte_w({a, 1'b0}, k); mask[0] = k;
        byte_w(cmd, k);       mask[1] = k;
        bus_start();
        byte_w({a, 1'b1}, k); mask[2] = k;
        for (int i = 0; i < n; i++) byte_r(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic byte_write(input int idx, input logic [7:0] v, output logic [63:0] mask);
        wbuf[0] = 8'h80 | 8'(idx);
        wbuf[1] = v;
        wr_xfer(dev, 2, mask);
    endtask

    task automatic byte_read(input int idx, output logic [7:0] v);
        logic [2:0] m;
        rd_xfer(dev, 8'h80 | 8'(idx), 1, m);
        v = rbuf[0];
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] mk;
        logic [2:0]  rm;
        logic [7:0]  v;
        int idx;
        void'($urandom(32'd1357));

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 reset enables", out_en, 20'hFFFFF);

        // R2: every strap combination, own address and a foreign one
        for (int h = 0; h < 3; h++) begin
            for (int l = 0; l < 3; l++) begin
                pwr_good = 1'b0;
                strap_hi = 2'(h); strap_lo = 2'(l);
                repeat (4) @(negedge clk);
                pwr_good = 1'b1;
                repeat (4) @(negedge clk);
                wr_xfer(exp_addr(h, l), 0, mk);
                chk("R2 own address acked", mk[0], 1'b1);
                wr_xfer(exp_addr(h, l) ^ 7'h10, 0, mk);
                chk("R2 foreign address nacked", mk[0], 1'b0);
            end
        end
        // strap code 3 counts as H: HH
        pwr_good = 1'b0; strap_hi = 2'd3; strap_lo = 2'd3;
        repeat (4) @(negedge clk);
        pwr_good = 1'b1;
        repeat (4) @(negedge clk);
        wr_xfer(exp_addr(2, 2), 0, mk);
        chk("R2 code 3 as H", mk[0], 1'b1);
        pwr_good = 1'b0; strap_hi = 2'd1; strap_lo = 2'd2;
        repeat (4) @(negedge clk);
        pwr_good = 1'b1;
        repeat (4) @(negedge clk);
        dev = exp_addr(1, 2);

        // R4/R7: block write to indices 0..2
        wbuf[0] = 8'h00; wbuf[1] = 8'd3;
        for (int i = 0; i < 3; i++) wbuf[2+i] = 8'($urandom());
        wr_xfer(dev, 5, mk);
        chk("R4 block write acks", mk, 64'h3F);
        for (int i = 0; i < 3; i++) m_wr(i, wbuf[2+i]);
        chk("R7 output enable mapping", out_en, m_en);

        // R6/R1/R8: block read of whole map, default count 8
        oe_pin_n = 8'($urandom());
        rd_xfer(dev, 8'h00, 9, rm);
        chk("R6 block read acks", rm, 3'b111);
        chk("R1 R6 count byte default", rbuf[0], 8'h08);
        for (int i = 0; i < 8; i++) chk("R6 R7 R8 block read data", rbuf[1+i], exp_reg(i));

        // R3/R8/R9: random single-byte writes and reads
        for (int n = 0; n < 20; n++) begin
            idx = int'($urandom_range(0, 7));
            v = 8'($urandom());
            if (idx == 7) v = v & 8'h1F;
            byte_write(idx, v, mk);
            chk("R3 byte write acks", mk, 64'h7);
            m_wr(idx, v);
            oe_pin_n = 8'($urandom());
            byte_read(idx, v);
            chk("R3 R8 R9 byte read", v, exp_reg(idx));
        end
        chk("R7 enables after random", out_en, m_en);

        // R3: second data byte in byte mode is refused and not stored
        wbuf[0] = 8'h81; wbuf[1] = 8'h5A; wbuf[2] = 8'hA5;
        wr_xfer(dev, 3, mk);
        chk("R3 extra byte nacked", mk, 64'h7);
        m_wr(1, 8'h5A);
        chk("R3 extra byte not stored", out_en, m_en);

        // R8: read-only registers ignore writes
        byte_write(5, 8'hFF, mk);
        byte_read(5, v);
        chk("R8 reg5 write ignored", v, 8'h23);
        byte_write(6, 8'h00, mk);
        byte_read(6, v);
        chk("R8 reg6 write ignored", v, 8'h5C);
        byte_write(4, 8'hFF, mk);
        byte_read(4, v);
        chk("R8 reg4 reads zero", v, 8'h00);

        // R9: upper bits of register 7, then a shorter read-back count
        byte_write(7, 8'hFF, mk);
        m_wr(7, 8'hFF);
        byte_read(7, v);
        chk("R9 reg7 masked", v, 8'h3F);
        byte_write(7, 8'h04, mk);
        m_wr(7, 8'h04);
        rd_xfer(dev, 8'h01, 3, rm);
        chk("R6 R9 programmed count", rbuf[0], 8'h04);
        chk("R6 data from start index", rbuf[1], exp_reg(1));
        chk("R6 index advances", rbuf[2], exp_reg(2));

        // R5: counts 0 and 33 refused, registers untouched
        wbuf[0] = 8'h00; wbuf[1] = 8'd0; wbuf[2] = 8'h00;
        wr_xfer(dev, 3, mk);
        chk("R5 count zero nacked", mk, 64'h3);
        chk("R5 count zero no change", out_en, m_en);
        wbuf[1] = 8'd33;
        wr_xfer(dev, 3, mk);
        chk("R5 count 33 nacked", mk, 64'h3);
        chk("R5 count 33 no change", out_en, m_en);

        // R4: count 32 from index 0 acknowledges every byte
        wbuf[0] = 8'h00; wbuf[1] = 8'd32;
        for (int i = 0; i < 32; i++) wbuf[2+i] = 8'($urandom());
        wbuf[2+7] = 8'h08;
        wr_xfer(dev, 34, mk);
        chk("R4 count 32 acks", mk, 64'h7_FFFF_FFFF);
        for (int i = 0; i < 8; i++) m_wr(i, wbuf[2+i]);
        chk("R4 count 32 enables", out_en, m_en);

        // R10: one-sample glitches on the clock line and on the data line
        v = 8'($urandom()) | 8'h01;
        bit_no = 0;
        glitch_at = 9 + 9 + 3;
        glitch_sda = 0;
        byte_write(1, v, mk);
        glitch_at = -1;
        m_wr(1, v);
        chk("R10 scl glitch ignored", out_en, m_en);
        bit_no = 0;
        glitch_at = 9 + 9 + 7;
        glitch_sda = 1;
        byte_write(2, v, mk);
        glitch_at = -1;
        m_wr(2, v);
        chk("R10 sda glitch ignored", out_en, m_en);

        // R11: power-good low makes the slave deaf
        pwr_good = 1'b0;
        repeat (4) @(negedge clk);
        byte_write(1, ~m_en[7:0], mk);
        chk("R11 no ack while down", mk, 64'h0);
        chk("R11 no store while down", out_en, m_en);
        pwr_good = 1'b1;
        repeat (4) @(negedge clk);
        byte_read(1, v);
        chk("R11 active again", v, exp_reg(1));

        chk("R12 drive stable while clock high", 32'(r12_bad), 32'd0);

        done = 1;
        finish_run();
    end
endmodule